// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage, in-order integer pipeline. Each cycle it looks at the two source register numbers of the instruction about to use the ALU. It compares them with the destination numbers still travelling in the two later stages, whose results have not yet reached the register file. For each of the two ALU operands it returns a 2-bit select. The operand multiplexers outside the block use that select to take the register-file read, the result waiting in the memory-stage latch, or the result waiting in the writeback-stage latch.

The block is purely combinational and has no clock or reset. A later stage can supply a value only if it is going to write a register, and that register is not register zero, and its number equals the operand's source number. The memory-stage latch holds the younger instruction. When both later stages can supply the same operand, the memory-stage value is selected, so a chain of dependent writes always feeds the newest result forward. The first operand takes its source from the first source field and the second operand from the second source field, and the two are decided separately.

Top module: `fwd_select_unit`

## Requirements
- R1: Select encoding: 2'b00 selects the register-file value, 2'b10 selects the memory-stage (younger) result, and 2'b01 selects the writeback-stage (older) result. With no matching stage the select is 2'b00.
- R2: An operand selects 2'b10 when `exm_wr_i` is 1, `exm_dst_i` is nonzero and `exm_dst_i` equals that operand's source number. If `exm_wr_i` is 0 or the numbers differ, the memory stage is not selected.
- R3: An operand selects 2'b01 when `mwb_wr_i` is 1, `mwb_dst_i` is nonzero, `mwb_dst_i` equals that operand's source number and R2 does not select the memory stage. If `mwb_wr_i` is 0 or the numbers differ, the writeback stage is not selected.
- R4: When both later stages qualify for the same operand, the select is 2'b10.
- R5: A source number of zero always gives 2'b00, even when a stage has write enabled and destination zero.
- R6: `sel_a_o` depends only on `src_a_i` and `sel_b_o` depends only on `src_b_i` (together with the shared stage inputs), so the two operands can receive different selects in the same cycle.
- R7: The code 2'b11 never appears on either select.
- R8: The selects follow any input change without waiting for a clock edge.
- R9: For a run of back-to-back instructions that each add one to the same register, the selected operand equals the latest value of that register in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | 5 | First source register number of the execute-stage instruction |
| src_b_i | input | 5 | Second source register number of the execute-stage instruction |
| exm_wr_i | input | 1 | Memory-stage instruction will write a register |
| exm_dst_i | input | 5 | Memory-stage destination register number |
| mwb_wr_i | input | 1 | Writeback-stage instruction will write a register |
| mwb_dst_i | input | 5 | Writeback-stage destination register number |
| sel_a_o | output | 2 | First-operand source select (00 file, 10 memory stage, 01 writeback stage) |
| sel_b_o | output | 2 | Second-operand source select, same encoding |

## Verification
The block holds no state, so any error shows up on the selects in the same evaluation as the input pattern that exposes it. No later cycle is needed to see it. A wrong priority shows up only when both stages name the same register. A missing zero guard shows up only with source zero and a writing stage whose destination is zero. A crossed operand wiring shows up only when the two source numbers differ. The bench therefore builds each of these patterns on purpose. It also runs a three-step increment chain through a small operand-mux model, where choosing a stale stage gives a value that is off by one at once.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_W  = 5;   // register number width
    localparam int N_STG  = 2;   // later stages that can supply a value, youngest first
    localparam int N_OPS  = 2;   // ALU operands

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_MWB = 2'b01,
        SRC_EXM = 2'b10
    } fwd_src_e;

    typedef struct packed {
        logic     wr;
        reg_idx_t dst;
    } wb_tap_t;

    // stage index (0 = youngest) to select code
    function automatic fwd_src_e stage_code(input int idx);
        case (idx)
            0:       return SRC_EXM;
            1:       return SRC_MWB;
            default: return SRC_RF;
        endcase
    endfunction

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match
    import fwd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         wr_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    output logic         hit_o
);

    logic dst_live;

    // register zero is hard-wired, never a bypass source
    always_comb begin
        dst_live = wr_i && (dst_i != '0);
        hit_o    = dst_live && (dst_i == src_i);
    end

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int NSTG = N_STG
) (
    input  reg_idx_t                src_i,
    input  wb_tap_t [NSTG-1:0]      taps_i,
    output fwd_src_e                sel_o
);

    logic [NSTG-1:0] hit;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        fwd_stage_match #(.W(REG_W)) u_match (
            .wr_i  (taps_i[g].wr),
            .dst_i (taps_i[g].dst),
            .src_i (src_i),
            .hit_o (hit[g])
        );
    end

    // walk oldest to youngest, so the youngest hit is written last and wins
    always_comb begin
        sel_o = SRC_RF;
        for (int s = NSTG - 1; s >= 0; s--) begin
            if (hit[s]) sel_o = stage_code(s);
        end
    end

    always_comb begin
        if (!$isunknown({src_i, taps_i, sel_o})) begin
            AST_NO_CODE_ELEVEN: assert (sel_o != 2'b11) else $error("illegal select");  // R7
            AST_ZERO_SRC_FILE: assert (src_i != '0 || sel_o == SRC_RF) else $error("r0 bypassed");  // R5
            AST_YOUNG_WINS: assert (!(taps_i[0].wr && taps_i[0].dst == src_i && src_i != '0) || sel_o == SRC_EXM) else $error("priority");  // R4
            AST_QUIET_FILE: assert (taps_i[0].wr || taps_i[NSTG-1].wr || sel_o == SRC_RF) else $error("bypass without write");  // R2
        end
    end

endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
    import fwd_pkg::*;
(
    input  logic [4:0] src_a_i,
    input  logic [4:0] src_b_i,
    input  logic       exm_wr_i,
    input  logic [4:0] exm_dst_i,
    input  logic       mwb_wr_i,
    input  logic [4:0] mwb_dst_i,
    output logic [1:0] sel_a_o,
    output logic [1:0] sel_b_o
);

    wb_tap_t [N_STG-1:0] taps;
    reg_idx_t            src [N_OPS];
    fwd_src_e            sel [N_OPS];

    always_comb begin
        taps[0] = '{wr: exm_wr_i, dst: exm_dst_i};
        taps[1] = '{wr: mwb_wr_i, dst: mwb_dst_i};
        src[0]  = src_a_i;
        src[1]  = src_b_i;
    end

    for (genvar op = 0; op < N_OPS; op++) begin : g_op
        fwd_operand_sel #(.NSTG(N_STG)) u_sel (
            .src_i  (src[op]),
            .taps_i (taps),
            .sel_o  (sel[op])
        );
    end

    assign sel_a_o = sel[0];
    assign sel_b_o = sel[1];

    always_comb begin
        if (!$isunknown({src_a_i, src_b_i, mwb_wr_i, mwb_dst_i, sel_a_o, sel_b_o})) begin
            AST_OLD_STAGE_OK: assert (sel_a_o != 2'b01 || (mwb_wr_i && mwb_dst_i == src_a_i)) else $error("old stage mismatch");  // R3
            AST_B_OWN_SRC: assert (sel_b_o != 2'b01 || (mwb_wr_i && mwb_dst_i == src_b_i)) else $error("operand b crossed");  // R6
        end
    end

endmodule

// File: tb/sim_fwd_select_unit.sv
module sim_fwd_select_unit;

    logic       clk = 1'b0;
    logic [4:0] sa, sb, ed, md;
    logic       ew, mw;
    logic [1:0] sel_a, sel_b;
    int         n_run = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fwd_select_unit u0 (
        .src_a_i (sa), .src_b_i (sb),
        .exm_wr_i(ew), .exm_dst_i(ed),
        .mwb_wr_i(mw), .mwb_dst_i(md),
        .sel_a_o (sel_a), .sel_b_o (sel_b)
    );

    // {req, sa, sb, ew, ed, mw, md, exp_a, exp_b}
    localparam int NV = 12;
    localparam logic [29:0] VEC [NV] = '{
        {4'd1, 5'd0,  5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00},  // R1 idle
        {4'd2, 5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00},  // R2 hit
        {4'd2, 5'd3,  5'd4,  1'b0, 5'd3,  1'b0, 5'd0,  2'b00, 2'b00},  // R2 no write
        {4'd3, 5'd7,  5'd9,  1'b0, 5'd0,  1'b1, 5'd9,  2'b00, 2'b01},  // R3 hit
        {4'd5, 5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},  // R5 zero
        {4'd4, 5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  2'b10, 2'b10},  // R4 both
        {4'd6, 5'd6,  5'd2,  1'b1, 5'd6,  1'b1, 5'd2,  2'b10, 2'b01},  // R6
        {4'd6, 5'd2,  5'd6,  1'b1, 5'd6,  1'b1, 5'd2,  2'b01, 2'b10},  // R6 swapped
        {4'd2, 5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0,  2'b10, 2'b10},  // R2 top reg
        {4'd3, 5'd12, 5'd13, 1'b0, 5'd12, 1'b1, 5'd12, 2'b01, 2'b00},  // R3 fallback
        {4'd3, 5'd1,  5'd1,  1'b1, 5'd2,  1'b0, 5'd1,  2'b00, 2'b00},  // R3 no write
        {4'd2, 5'd10, 5'd11, 1'b1, 5'd12, 1'b1, 5'd13, 2'b00, 2'b00}   // R2 mismatch
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic xw,
                         input logic [4:0] xd, input logic yw, input logic [4:0] yd);
        sa = a; sb = b; ew = xw; ed = xd; mw = yw; md = yd;
    endtask

    // bench operand mux model for R9
    function automatic int pick(input logic [1:0] s, input int rf, input int xv, input int yv);
        case (s)
            2'b10:   return xv;
            2'b01:   return yv;
            default: return rf;
        endcase
    endfunction

    initial begin
        drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
        @(negedge clk); #1;
        chk("R1 quiet", {28'd0, sel_a, sel_b}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][25:21], VEC[i][20:16], VEC[i][15], VEC[i][14:10], VEC[i][9], VEC[i][8:4]);
            #1;
            chk($sformatf("R%0d vec%0d a", VEC[i][29:26], i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
            chk($sformatf("R%0d vec%0d b", VEC[i][29:26], i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
            chk("R7 no 11", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
        end

        // R5: source zero, stage writes r0
        @(negedge clk);
        drive(5'd0, 5'd4, 1'b1, 5'd0, 1'b1, 5'd4);
        #1;
        chk("R5 r0 a", {30'd0, sel_a}, 32'd0);
        chk("R5 other b", {30'd0, sel_b}, 32'd1);

        // R8: change inputs between edges, no clock edge in between
        @(posedge clk); #3;
        drive(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8);
        #1;
        chk("R8 before", {28'd0, sel_a, sel_b}, 32'h0);
        ew = 1'b1;
        #1;
        chk("R8 after", {28'd0, sel_a, sel_b}, 32'ha);

        // R9: three back-to-back increments of r1, starting at 5
        begin
            int rf1;
            int res [3];
            rf1 = 5;
            for (int k = 0; k < 3; k++) begin
                int xv, yv, opv;
                @(negedge clk);
                xv = (k >= 1) ? res[k-1] : 0;
                yv = (k >= 2) ? res[k-2] : 0;
                drive(5'd1, 5'd0, k >= 1, (k >= 1) ? 5'd1 : 5'd0, k >= 2, (k >= 2) ? 5'd1 : 5'd0);
                #1;
                opv = pick(sel_a, rf1, xv, yv);
                chk($sformatf("R9 step%0d", k), opv, 5 + k);
                res[k] = opv + 1;
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule